// File: doc/BRIEF.md
# Endpoint Receive Buffer Word-Drain Controller

This block sits between the byte-wide receive buffer of one USB endpoint and a DMA engine that moves 32-bit words. Packet bytes are written into the buffer one at a time. A closing strobe then latches the packet length and raises a receive-ready flag. While DMA is enabled and a transfer is running, the block requests words until the packet is drained. It then decides whether the drain clears the ready flag. The read side always works in 4-byte units, so the decision depends on how the packet's word count compares with that of the configured maximum packet size.

A transfer length in bytes is loaded by software. It counts down by four for every word moved, and DMA requests are issued only when the loaded length is at least a minimum DMA size. Shorter transfers are unloaded through a byte-wide programmed read port. The interrupt can be raised once per drained packet or once per completed transfer. It shares one output with the plain "packet waiting" event seen when DMA is off. A packet that closes while the ready flag is still set is dropped and flagged as an overrun.

Top module: `urx_dma_unload`

## Requirements
- R1: After reset, rxReady, ovrFlag, intOut and dmaReq are all low.
- R2: dmaReq is high only when cfgDmaEn is set, rxReady is set, unread packet bytes remain, the most recently loaded transfer length was at least MIN_DMA_BYTES (64), and the remaining transfer count is non-zero.
- R3: Each DMA word carries packet byte 4n+k in bits [8k+7:8k] for word n, with bytes at or past the packet length read as zero. A packet of L bytes takes ceil(L/4) words when the transfer count does not run out.
- R4: Taking the last word of a packet clears rxReady when the packet is at most G bytes shorter than cfgMaxPkt, where G is 3 when cfgMaxPkt mod 4 is 0 and (cfgMaxPkt mod 4) minus 1 otherwise.
- R5: Otherwise rxReady stays set after draining until a clrReady pulse.
- R6: With cfgIntMode = 0, the interrupt status is set by the last DMA word of every packet.
- R7: With cfgIntMode = 1, the interrupt status is set only by the DMA word that brings the remaining transfer count to zero. The count drops by 4 per word and saturates at 0.
- R8: intOut is the sticky interrupt status ORed with (rxReady and not cfgDmaEn). A clrInt pulse clears the status.
- R9: inPktDone while rxReady is set sets ovrFlag until clrOvr. The new packet is dropped, and the held packet and its byte writes are left untouched.
- R10: pioData shows the next unread packet byte, or zero when none is left. Each pioRd pulse advances the read position by one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDmaEn | input | 1 | Receive DMA enable |
| cfgIntMode | input | 1 | 0: interrupt per packet, 1: interrupt at end of transfer |
| cfgMaxPkt | input | LEN_W | Maximum packet size in bytes |
| cfgXferLoad | input | 1 | Load pulse for the transfer length |
| cfgXferLen | input | XFER_W | Transfer length in bytes |
| inWrEn | input | 1 | Byte write strobe from packet reception |
| inWrData | input | 8 | Byte to write |
| inPktDone | input | 1 | Packet close strobe |
| clrReady | input | 1 | Write-one-to-clear of the ready flag |
| clrInt | input | 1 | Write-one-to-clear of the interrupt status |
| clrOvr | input | 1 | Write-one-to-clear of the overrun flag |
| pioRd | input | 1 | Programmed byte read pulse |
| pioData | output | 8 | Next unread byte |
| dmaReq | output | 1 | DMA word request |
| dmaAck | input | 1 | DMA takes the presented word |
| dmaData | output | 32 | Presented word |
| rxReady | output | 1 | Receive-ready flag |
| ovrFlag | output | 1 | Overrun flag |
| intOut | output | 1 | Endpoint interrupt |

## Verification
A wrong read pointer shows up on dmaData or pioData in the very next word or byte presented. A wrong qualification decision shows on rxReady one cycle after the last acknowledged word. A transfer counter that drifts changes the word count at which dmaReq falls, and it moves the intOut edge by at least one word in end-of-transfer mode. The sweeps cover every residue of the maximum size, with packet sizes from the maximum down to four bytes shorter, so each of these errors appears at the ports within one packet.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef struct packed {
    logic wrByte;
    logic latchPkt;
    logic dmaPop;
    logic pioPop;
  } urxStrobe_t;
endpackage

// File: rtl/urx_datapath.sv
module urx_datapath
  import urx_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int LEN_W = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  urxStrobe_t       st,
  input  logic [7:0]       inWrData,
  output logic [LEN_W-1:0] pktLen,
  output logic [LEN_W-1:0] pendBytes,
  output logic [31:0]      wordData,
  output logic [7:0]       byteData
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int PTR_W = LEN_W + 1;

  logic [7:0]       mem [BUF_BYTES];
  logic [LEN_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] lenWide;

  assign lenWide = {1'b0, pktLen};

  always_ff @(posedge clk) begin
    if (st.wrByte && wrPtr < LEN_W'(BUF_BYTES))
      mem[wrPtr[IDX_W-1:0]] <= inWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      pktLen <= '0;
    end else begin
      if (st.latchPkt) begin
        pktLen <= wrPtr;
        wrPtr  <= '0;
        rdPtr  <= '0;
      end else begin
        if (st.wrByte && wrPtr < LEN_W'(BUF_BYTES))
          wrPtr <= wrPtr + 1'b1;
        if (st.dmaPop)
          rdPtr <= rdPtr + PTR_W'(4);
        else if (st.pioPop)
          rdPtr <= rdPtr + 1'b1;
      end
    end
  end

  always_comb begin
    if (rdPtr < lenWide) pendBytes = LEN_W'(lenWide - rdPtr);
    else                 pendBytes = '0;
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [PTR_W-1:0] pos;
    assign pos = rdPtr + PTR_W'(k);
    assign wordData[8*k +: 8] = (pos < lenWide) ? mem[pos[IDX_W-1:0]] : 8'h00;
  end

  assign byteData = wordData[7:0];
endmodule

// File: rtl/urx_control.sv
module urx_control
  import urx_pkg::*;
#(
  parameter int LEN_W = 7,
  parameter int XFER_W = 16,
  parameter int MIN_DMA_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDmaEn,
  input  logic              cfgIntMode,
  input  logic [LEN_W-1:0]  cfgMaxPkt,
  input  logic              cfgXferLoad,
  input  logic [XFER_W-1:0] cfgXferLen,
  input  logic              inWrEn,
  input  logic              inPktDone,
  input  logic              clrReady,
  input  logic              clrInt,
  input  logic              clrOvr,
  input  logic              pioRd,
  input  logic              dmaAck,
  input  logic [LEN_W-1:0]  pktLen,
  input  logic [LEN_W-1:0]  pendBytes,
  output urxStrobe_t        st,
  output logic              dmaReq,
  output logic              rxReady,
  output logic              ovrFlag,
  output logic              intOut
);
  logic [XFER_W-1:0] xferLeft;
  logic              xferOk;
  logic              intSts;
  logic              lastWord;
  logic              sameWords;
  logic              intSet;
  logic [LEN_W:0]    pktWords;
  logic [LEN_W:0]    maxWords;

  assign pktWords  = ({1'b0, pktLen} + (LEN_W+1)'(3)) >> 2;
  assign maxWords  = ({1'b0, cfgMaxPkt} + (LEN_W+1)'(3)) >> 2;
  assign sameWords = (pktWords == maxWords);
  assign lastWord  = (pendBytes != '0) && (pendBytes <= LEN_W'(4));

  assign dmaReq = cfgDmaEn && rxReady && (pendBytes != '0) && xferOk && (xferLeft != '0);

  always_comb begin
    st = '0;
    st.wrByte   = inWrEn && !rxReady;
    st.latchPkt = inPktDone && !rxReady;
    st.dmaPop   = dmaReq && dmaAck;
    st.pioPop   = pioRd && !st.dmaPop && rxReady && (pendBytes != '0);
  end

  assign intSet = st.dmaPop && (cfgIntMode ? (xferLeft <= XFER_W'(4)) : lastWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReady  <= 1'b0;
      ovrFlag  <= 1'b0;
      intSts   <= 1'b0;
      xferLeft <= '0;
      xferOk   <= 1'b0;
    end else begin
      if (st.latchPkt)
        rxReady <= 1'b1;
      else if (clrReady || (st.dmaPop && lastWord && sameWords))
        rxReady <= 1'b0;

      if (inPktDone && rxReady) ovrFlag <= 1'b1;
      else if (clrOvr)          ovrFlag <= 1'b0;

      if (intSet)      intSts <= 1'b1;
      else if (clrInt) intSts <= 1'b0;

      if (cfgXferLoad) begin
        xferLeft <= cfgXferLen;
        xferOk   <= (cfgXferLen >= XFER_W'(MIN_DMA_BYTES));
      end else if (st.dmaPop) begin
        xferLeft <= (xferLeft > XFER_W'(4)) ? xferLeft - XFER_W'(4) : '0;
      end
    end
  end

  assign intOut = intSts || (rxReady && !cfgDmaEn);
endmodule

// File: rtl/urx_dma_unload.sv
module urx_dma_unload
  import urx_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int LEN_W = $clog2(BUF_BYTES + 1),
  parameter int XFER_W = 16,
  parameter int MIN_DMA_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDmaEn,
  input  logic              cfgIntMode,
  input  logic [LEN_W-1:0]  cfgMaxPkt,
  input  logic              cfgXferLoad,
  input  logic [XFER_W-1:0] cfgXferLen,
  input  logic              inWrEn,
  input  logic [7:0]        inWrData,
  input  logic              inPktDone,
  input  logic              clrReady,
  input  logic              clrInt,
  input  logic              clrOvr,
  input  logic              pioRd,
  output logic [7:0]        pioData,
  output logic              dmaReq,
  input  logic              dmaAck,
  output logic [31:0]       dmaData,
  output logic              rxReady,
  output logic              ovrFlag,
  output logic              intOut
);
  urxStrobe_t       st;
  logic [LEN_W-1:0] pktLen;
  logic [LEN_W-1:0] pendBytes;

  urx_control #(.LEN_W(LEN_W), .XFER_W(XFER_W), .MIN_DMA_BYTES(MIN_DMA_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgDmaEn(cfgDmaEn), .cfgIntMode(cfgIntMode),
    .cfgMaxPkt(cfgMaxPkt), .cfgXferLoad(cfgXferLoad), .cfgXferLen(cfgXferLen),
    .inWrEn(inWrEn), .inPktDone(inPktDone), .clrReady(clrReady), .clrInt(clrInt),
    .clrOvr(clrOvr), .pioRd(pioRd), .dmaAck(dmaAck), .pktLen(pktLen),
    .pendBytes(pendBytes), .st(st), .dmaReq(dmaReq), .rxReady(rxReady),
    .ovrFlag(ovrFlag), .intOut(intOut)
  );

  urx_datapath #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inWrData(inWrData), .pktLen(pktLen),
    .pendBytes(pendBytes), .wordData(dmaData), .byteData(pioData)
  );
endmodule

// File: rtl/urx_dma_unload_chk.sv
module urx_dma_unload_chk (
  input logic clk,
  input logic rstN,
  input logic cfgDmaEn,
  input logic rxReady,
  input logic clrReady,
  input logic dmaReq,
  input logic dmaAck,
  input logic inPktDone,
  input logic ovrFlag,
  input logic clrOvr,
  input logic intOut,
  input logic clrInt
);
  a_r2_req_gated: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (cfgDmaEn && rxReady));

  a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !clrReady && !(dmaReq && dmaAck)) |=> rxReady);

  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (inPktDone && rxReady) |=> ovrFlag);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !clrOvr) |=> ovrFlag);

  a_r8_int_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (intOut && cfgDmaEn && !clrInt) |=> (intOut || !cfgDmaEn));
endmodule

bind urx_dma_unload urx_dma_unload_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgDmaEn(cfgDmaEn), .rxReady(rxReady),
  .clrReady(clrReady), .dmaReq(dmaReq), .dmaAck(dmaAck), .inPktDone(inPktDone),
  .ovrFlag(ovrFlag), .clrOvr(clrOvr), .intOut(intOut), .clrInt(clrInt)
);

// File: tb/sim_urx_dma_unload.sv
`timescale 1ns/1ps
module sim_urx_dma_unload;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgDmaEn = 0, cfgIntMode = 0, cfgXferLoad = 0;
  logic [6:0]  cfgMaxPkt = 7'd64;
  logic [15:0] cfgXferLen = '0;
  logic        inWrEn = 0, inPktDone = 0, clrReady = 0, clrInt = 0, clrOvr = 0;
  logic        pioRd = 0, dmaAck = 0;
  logic [7:0]  inWrData = '0;
  logic [7:0]  pioData;
  logic [31:0] dmaData;
  logic        dmaReq, rxReady, ovrFlag, intOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  urx_dma_unload u0 (.*);

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) & 255);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic loadXfer(input int len);
    cfgXferLen = 16'(len); cfgXferLoad = 1; tick(); cfgXferLoad = 0;
  endtask

  task automatic sendPkt(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      inWrEn = 1; inWrData = pat(i, seed); tick();
    end
    inWrEn = 0; inPktDone = 1; tick(); inPktDone = 0;
  endtask

  task automatic clearAll();
    clrReady = 1; clrInt = 1; tick(); clrReady = 0; clrInt = 0;
  endtask

  task automatic drain(input int len, input int seed, input int expWords,
                       input bit expReady, input bit expInt);
    int n = 0;
    while (dmaReq && n < 20) begin
      logic [31:0] e;
      for (int k = 0; k < 4; k++)
        e[8*k +: 8] = (4*n + k < len) ? pat(4*n + k, seed) : 8'h00;
      check($sformatf("R3 word %0d len %0d", n, len), dmaData, e);
      dmaAck = 1; tick(); dmaAck = 0;
      n++;
    end
    check($sformatf("R3 word count len %0d max %0d", len, cfgMaxPkt), 32'(n), 32'(expWords));
    check($sformatf("R4/R5 ready len %0d max %0d", len, cfgMaxPkt), 32'(rxReady), 32'(expReady));
    check($sformatf("R6/R7 interrupt len %0d", len), 32'(intOut), 32'(expInt));
    clearAll();
    check("R8 clear interrupt and ready", {30'd0, intOut, rxReady}, 32'd0);
  endtask

  initial begin
    int gap;
    bit qual;
    repeat (3) tick();
    check("R1 reset outputs", {28'd0, rxReady, ovrFlag, intOut, dmaReq}, 32'd0);
    rstN = 1; tick();

    // Per-packet sweep over small and full-size maxima, every residue mod 4
    cfgDmaEn = 1; cfgIntMode = 0;
    for (int m = 4; m <= 64; m++) begin
      if (m > 8 && m < 61) continue;
      cfgMaxPkt = 7'(m);
      for (int len = m; len >= m - 4 && len >= 1; len--) begin
        gap  = (m % 4 == 0) ? 3 : (m % 4) - 1;
        qual = (m - len) <= gap;
        loadXfer(16'hffff);
        sendPkt(len, m + len);
        check("R2 request after packet", 32'(dmaReq), 32'd1);
        drain(len, m + len, (len + 3) / 4, !qual, 1'b1);
      end
    end

    // End-of-transfer interrupt mode
    cfgIntMode = 1; cfgMaxPkt = 7'd64;
    loadXfer(128);
    sendPkt(64, 1); drain(64, 1, 16, 0, 0);
    sendPkt(64, 2); drain(64, 2, 16, 0, 1);
    sendPkt(64, 3);
    check("R2 no request once transfer exhausted", 32'(dmaReq), 32'd0);
    clearAll();
    loadXfer(100);
    sendPkt(64, 4); drain(64, 4, 16, 0, 0);
    sendPkt(40, 5); drain(40, 5, 9, 1, 1);  // R7: count hits zero mid-packet

    // Short transfer: no DMA, programmed byte reads
    cfgIntMode = 0;
    loadXfer(60);
    sendPkt(8, 6);
    check("R2 no request below minimum DMA length", 32'(dmaReq), 32'd0);
    for (int i = 0; i < 8; i++) begin
      check($sformatf("R10 pio byte %0d", i), 32'(pioData), 32'(pat(i, 6)));
      pioRd = 1; tick(); pioRd = 0;
    end
    check("R10 pio past end reads zero", 32'(pioData), 32'd0);
    check("R5 ready held after pio drain", 32'(rxReady), 32'd1);
    check("R8 no event while DMA enabled", 32'(intOut), 32'd0);
    cfgDmaEn = 0; tick();
    check("R8 ready event with DMA off", 32'(intOut), 32'd1);
    check("R2 no request with DMA off", 32'(dmaReq), 32'd0);
    clearAll();
    check("R8 event gone after ready clear", 32'(intOut), 32'd0);

    // Overrun
    sendPkt(5, 7);
    sendPkt(3, 8);
    check("R9 overrun set", 32'(ovrFlag), 32'd1);
    check("R9 held packet byte kept", 32'(pioData), 32'(pat(0, 7)));
    pioRd = 1; tick(); pioRd = 0;
    check("R9 held packet second byte kept", 32'(pioData), 32'(pat(1, 7)));
    clrOvr = 1; tick(); clrOvr = 0;
    check("R9 overrun cleared", 32'(ovrFlag), 32'd0);
    check("R9 ready still set", 32'(rxReady), 32'd1);
    clearAll();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule